// File: doc/BRIEF.md
# PTP System Time Control Unit

This block keeps a precision network time made of a 32-bit seconds count and a 31-bit subseconds count. The subseconds roll into the seconds at 2^31. Frame time stamping elsewhere in the chip reads that time. Software drives the block through a small register window. A control word holds the enable and mode bits plus three self-clearing commands: load the time, shift it by a signed offset, and copy a new frequency-trim addend into the time engine. A fourth command bit arms a one-shot target-time interrupt.

Time moves only on a reference tick. In coarse mode each tick adds the subsecond increment. In fine mode each tick adds the active addend to a 32-bit accumulator, and the increment is applied only on ticks where that accumulator carries out. A four-state machine owns the load and offset commands, so at most one of them can be pending. Its states are ST_OFF (stamping disabled, time frozen), ST_RUN (free running), ST_LOAD (time load pending) and ST_ADJ (offset pending). Its transitions are: *disable* (any state to ST_OFF on a control write with bit 0 clear), *enable* (ST_OFF to ST_RUN, ST_LOAD or ST_ADJ on a control write with bit 0 set), *request* (ST_RUN to ST_LOAD or ST_ADJ), and *complete* (ST_LOAD or ST_ADJ to ST_RUN on the next tick).

Top module: `ptp_sys_time`

## Requirements
- R1: After reset every register reads zero, the time is 0 s / 0 subseconds, `stamp_en` and `trig_irq` are low, and control bits 31:6 always read zero.
- R2: While control bit 0 (enable) is clear, ticks leave the time unchanged and `stamp_en` is low. Bit 0 reads 1 whenever the block is enabled.
- R3: Control bit 2 (load) takes effect on the first tick after it is accepted. The seconds take the value at 0x08, the subseconds take bits 30:0 of 0x0C, and the fine accumulator is cleared. The time does not advance on that tick, and bit 2 then reads 0.
- R4: Bit 2 or bit 3 is accepted only while both read 0. A write setting both accepts only bit 2. Writing 0 to bit 2, 3 or 5 does not clear a pending command.
- R5: Control bit 3 (offset) applies the offset on the next tick, with 0x08 as seconds and 0x0C bits 30:0 as subseconds. Bit 31 of 0x0C set means subtract. A subsecond carry or borrow across 2^31 moves the seconds by one. Bit 3 then reads 0.
- R6: With control bit 1 clear (coarse), every tick in ST_RUN adds the 8-bit increment at 0x04 to the subseconds. Overflow past 2^31 - 1 wraps the subseconds and adds one second, and the seconds wrap modulo 2^32.
- R7: With control bit 1 set (fine), every tick in ST_RUN adds the active addend to the accumulator. The increment is added to the subseconds only on ticks where that sum carries out of 32 bits.
- R8: Control bit 5 is accepted only while it reads 0. On the next enabled tick it copies register 0x10 into the active addend and reads 0 again. The advance on that same tick still uses the previous addend.
- R9: While bit 4 (arm) and enable are set and the time is strictly greater than the target (seconds 0x14, subseconds 0x18), `trig_irq` pulses high for one cycle, one cycle later. Bit 4 clears at the same edge. Equality does not fire.
- R10: A control write with bit 0 clear cancels any pending load, offset or addend command. Re-enabling without a new command leaves the time unchanged.
- R11: The register map is: control 0x00, increment 0x04 (bits 7:0, upper bits read 0), offset/load seconds 0x08, offset/load subseconds with sign 0x0C, addend 0x10, target seconds 0x14, target subseconds 0x18, and read-only time at 0x1C (seconds) and 0x20 (subseconds).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ref_tick | input | 1 | One-cycle reference tick that advances time |
| stamp_en | output | 1 | High while time stamping is enabled |
| sys_sec | output | 32 | Current seconds |
| sys_subsec | output | 31 | Current subseconds |
| trig_irq | output | 1 | One-cycle target-time interrupt pulse |

## Verification
Two of the block's functions can fall on the same tick: the copy of a new addend and the load of the time. Each has its own pending flag, and both are set by one control write (0x27: enable, fine, load, addend). The bench then checks that a single tick clears both bits and loads the time without advancing it. It also checks that the two following ticks already use the new addend: one carry gives a subsecond value of 6, where the stale addend would leave it at 0.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;

    localparam int DW    = 32;
    localparam int AW    = 6;
    localparam int SEC_W = 32;
    localparam int SUB_W = 31;
    localparam int ACC_W = 32;

    localparam logic [AW-1:0] A_CTRL = 6'h00;
    localparam logic [AW-1:0] A_INCR = 6'h04;
    localparam logic [AW-1:0] A_UHI  = 6'h08;
    localparam logic [AW-1:0] A_ULO  = 6'h0C;
    localparam logic [AW-1:0] A_ADD  = 6'h10;
    localparam logic [AW-1:0] A_TSEC = 6'h14;
    localparam logic [AW-1:0] A_TSUB = 6'h18;
    localparam logic [AW-1:0] A_NSEC = 6'h1C;
    localparam logic [AW-1:0] A_NSUB = 6'h20;

    localparam int B_EN   = 0;
    localparam int B_FINE = 1;
    localparam int B_LOAD = 2;
    localparam int B_ADJ  = 3;
    localparam int B_ARM  = 4;
    localparam int B_ADDU = 5;
    localparam int CTRL_USED = 6;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_LOAD = 2'd2,
        ST_ADJ  = 2'd3
    } eng_state_t;

endpackage

// File: rtl/ptp_cmd_fsm.sv
module ptp_cmd_fsm
    import ptp_time_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] wdata,
    input  logic          tick,
    output eng_state_t    state,
    output logic          addend_pend,
    output logic          run_tick,
    output logic          load_go,
    output logic          adj_go,
    output logic          addend_go
);

    eng_state_t nxt;
    logic       disable_wr;

    assign disable_wr = ctrl_wr && !wdata[B_EN];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (disable_wr) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    if (ctrl_wr)
                        nxt = wdata[B_LOAD] ? ST_LOAD :
                              wdata[B_ADJ]  ? ST_ADJ  : ST_RUN;
                end
                ST_RUN: begin
                    if (ctrl_wr && wdata[B_LOAD])     nxt = ST_LOAD;
                    else if (ctrl_wr && wdata[B_ADJ]) nxt = ST_ADJ;
                end
                ST_LOAD: if (tick) nxt = ST_RUN;
                ST_ADJ:  if (tick) nxt = ST_RUN;
            endcase
        end
    end

    // strobes towards the time engine
    always_comb begin
        run_tick  = 1'b0;
        load_go   = 1'b0;
        adj_go    = 1'b0;
        unique case (state)
            ST_OFF:  ;
            ST_RUN:  run_tick = tick;
            ST_LOAD: load_go  = tick;
            ST_ADJ:  adj_go   = tick;
        endcase
        addend_go = tick && addend_pend && (state != ST_OFF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                         addend_pend <= 1'b0;
        else if (disable_wr)                addend_pend <= 1'b0;
        else if (addend_go)                 addend_pend <= 1'b0;
        else if (ctrl_wr && wdata[B_ADDU])  addend_pend <= 1'b1;
    end

    p_load_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && tick && !ctrl_wr) |=> (state == ST_RUN));

    p_hold_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !tick && ctrl_wr && wdata[B_EN]) |=> (state == ST_LOAD));

    p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        disable_wr |=> (state == ST_OFF && !addend_pend));

    p_addend_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addend_go && !ctrl_wr) |=> !addend_pend);

endmodule

// File: rtl/ptp_time_engine.sv
module ptp_time_engine
    import ptp_time_pkg::*;
#(
    parameter int INCR_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_tick,
    input  logic              load_go,
    input  logic              adj_go,
    input  logic              addend_go,
    input  logic              fine,
    input  logic [INCR_W-1:0] incr,
    input  logic [SEC_W-1:0]  upd_sec,
    input  logic [DW-1:0]     upd_lo,
    input  logic [ACC_W-1:0]  addend_in,
    output logic [SEC_W-1:0]  sec,
    output logic [SUB_W-1:0]  sub
);

    localparam int PAD = SUB_W + 1 - INCR_W;

    logic [ACC_W-1:0] acc, addend_act;
    logic [ACC_W:0]   acc_sum;
    logic             step;
    logic [SUB_W:0]   adv, adj_sum, adj_dif;
    logic [SUB_W-1:0] off;
    logic             neg;
    logic [SEC_W-1:0] sec_adj;
    logic [SUB_W-1:0] sub_adj;

    assign off = upd_lo[SUB_W-1:0];
    assign neg = upd_lo[DW-1];

    always_comb begin
        acc_sum = {1'b0, acc} + {1'b0, addend_act};
        step    = fine ? acc_sum[ACC_W] : 1'b1;
        adv     = {1'b0, sub} + (step ? {{PAD{1'b0}}, incr} : '0);
        adj_sum = {1'b0, sub} + {1'b0, off};
        adj_dif = {1'b0, sub} - {1'b0, off};
        if (neg) begin
            sec_adj = sec - upd_sec - {{(SEC_W-1){1'b0}}, adj_dif[SUB_W]};
            sub_adj = adj_dif[SUB_W-1:0];
        end else begin
            sec_adj = sec + upd_sec + {{(SEC_W-1){1'b0}}, adj_sum[SUB_W]};
            sub_adj = adj_sum[SUB_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec <= '0;
            sub <= '0;
            acc <= '0;
        end else if (load_go) begin
            sec <= upd_sec;
            sub <= off;
            acc <= '0;
        end else if (adj_go) begin
            sec <= sec_adj;
            sub <= sub_adj;
        end else if (run_tick) begin
            sub <= adv[SUB_W-1:0];
            sec <= sec + {{(SEC_W-1){1'b0}}, adv[SUB_W]};
            if (fine) acc <= acc_sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         addend_act <= '0;
        else if (addend_go) addend_act <= addend_in;
    end

    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_tick || load_go || adj_go) |=> ($stable(sec) && $stable(sub)));

    p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |=> (sec == $past(upd_sec) && sub == $past(upd_lo[SUB_W-1:0])));

    p_coarse_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick && !fine) |=> (SUB_W'(sub - $past(sub)) == SUB_W'($past(incr))));

    p_fine_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick && fine && addend_act == '0) |=> $stable(sub));

endmodule

// File: rtl/ptp_target_cmp.sv
module ptp_target_cmp
    import ptp_time_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             arm_wr,
    input  logic             arm_val,
    input  logic [SEC_W-1:0] sec,
    input  logic [SUB_W-1:0] sub,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [SUB_W-1:0] tgt_sub,
    output logic             arm,
    output logic             irq
);

    logic gt, fire;

    assign gt   = {sec, sub} > {tgt_sec, tgt_sub};
    assign fire = arm && en && gt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm <= 1'b0;
            irq <= 1'b0;
        end else begin
            irq <= fire;
            if (fire)        arm <= 1'b0;
            else if (arm_wr) arm <= arm_val;
        end
    end

    p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !arm);

    p_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> !irq);

endmodule

// File: rtl/ptp_regs.sv
module ptp_regs
    import ptp_time_pkg::*;
#(
    parameter int INCR_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  eng_state_t        state,
    input  logic              addend_pend,
    input  logic              arm,
    input  logic [SEC_W-1:0]  sec,
    input  logic [SUB_W-1:0]  sub,
    output logic              ctrl_wr,
    output logic              fine,
    output logic [INCR_W-1:0] incr,
    output logic [SEC_W-1:0]  upd_sec,
    output logic [DW-1:0]     upd_lo,
    output logic [ACC_W-1:0]  addend,
    output logic [SEC_W-1:0]  tgt_sec,
    output logic [SUB_W-1:0]  tgt_sub,
    output logic [DW-1:0]     rdata
);

    logic [CTRL_USED-1:0] ctrl_view;

    assign ctrl_wr = wr_en && (addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine    <= 1'b0;
            incr    <= '0;
            upd_sec <= '0;
            upd_lo  <= '0;
            addend  <= '0;
            tgt_sec <= '0;
            tgt_sub <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL: fine    <= wdata[B_FINE];
                A_INCR: incr    <= wdata[INCR_W-1:0];
                A_UHI:  upd_sec <= wdata[SEC_W-1:0];
                A_ULO:  upd_lo  <= wdata;
                A_ADD:  addend  <= wdata[ACC_W-1:0];
                A_TSEC: tgt_sec <= wdata[SEC_W-1:0];
                A_TSUB: tgt_sub <= wdata[SUB_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        ctrl_view         = '0;
        ctrl_view[B_EN]   = (state != ST_OFF);
        ctrl_view[B_FINE] = fine;
        ctrl_view[B_LOAD] = (state == ST_LOAD);
        ctrl_view[B_ADJ]  = (state == ST_ADJ);
        ctrl_view[B_ARM]  = arm;
        ctrl_view[B_ADDU] = addend_pend;
        case (addr)
            A_CTRL:  rdata = {{(DW-CTRL_USED){1'b0}}, ctrl_view};
            A_INCR:  rdata = {{(DW-INCR_W){1'b0}}, incr};
            A_UHI:   rdata = upd_sec;
            A_ULO:   rdata = upd_lo;
            A_ADD:   rdata = addend;
            A_TSEC:  rdata = tgt_sec;
            A_TSUB:  rdata = {1'b0, tgt_sub};
            A_NSEC:  rdata = sec;
            A_NSUB:  rdata = {1'b0, sub};
            default: rdata = '0;
        endcase
    end

    p_incr_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_INCR) |=> (incr == $past(wdata[INCR_W-1:0])));

    p_mode_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (fine == $past(wdata[B_FINE])));

endmodule

// File: rtl/ptp_sys_time.sv
module ptp_sys_time
    import ptp_time_pkg::*;
#(
    parameter int INCR_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             ref_tick,
    output logic             stamp_en,
    output logic [SEC_W-1:0] sys_sec,
    output logic [SUB_W-1:0] sys_subsec,
    output logic             trig_irq
);

    eng_state_t        state;
    logic              ctrl_wr, fine, addend_pend, arm;
    logic              run_tick, load_go, adj_go, addend_go;
    logic [INCR_W-1:0] incr;
    logic [SEC_W-1:0]  upd_sec, tgt_sec;
    logic [DW-1:0]     upd_lo;
    logic [ACC_W-1:0]  addend;
    logic [SUB_W-1:0]  tgt_sub;

    assign stamp_en = (state != ST_OFF);

    ptp_regs #(.INCR_W(INCR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .state(state), .addend_pend(addend_pend),
        .arm(arm), .sec(sys_sec), .sub(sys_subsec), .ctrl_wr(ctrl_wr),
        .fine(fine), .incr(incr), .upd_sec(upd_sec), .upd_lo(upd_lo),
        .addend(addend), .tgt_sec(tgt_sec), .tgt_sub(tgt_sub),
        .rdata(bus_rdata)
    );

    ptp_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
        .tick(ref_tick), .state(state), .addend_pend(addend_pend),
        .run_tick(run_tick), .load_go(load_go), .adj_go(adj_go),
        .addend_go(addend_go)
    );

    ptp_time_engine #(.INCR_W(INCR_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .run_tick(run_tick), .load_go(load_go),
        .adj_go(adj_go), .addend_go(addend_go), .fine(fine), .incr(incr),
        .upd_sec(upd_sec), .upd_lo(upd_lo), .addend_in(addend),
        .sec(sys_sec), .sub(sys_subsec)
    );

    ptp_target_cmp u_cmp (
        .clk(clk), .rst_n(rst_n), .en(stamp_en), .arm_wr(ctrl_wr),
        .arm_val(bus_wdata[B_ARM]), .sec(sys_sec), .sub(sys_subsec),
        .tgt_sec(tgt_sec), .tgt_sub(tgt_sub), .arm(arm), .irq(trig_irq)
    );

    p_disabled_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stamp_en && !bus_we) |=> ($stable(sys_sec) && $stable(sys_subsec)));

endmodule

// File: tb/sim_ptp_sys_time.sv
`timescale 1ns/1ps
module sim_ptp_sys_time;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_tick = 1'b0;
    logic        stamp_en;
    logic [31:0] sys_sec;
    logic [30:0] sys_subsec;
    logic        trig_irq;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    ptp_sys_time u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_tick(ref_tick),
        .stamp_en(stamp_en), .sys_sec(sys_sec), .sys_subsec(sys_subsec),
        .trig_irq(trig_irq)
    );

    localparam logic [5:0] CTRL = 6'h00, INCR = 6'h04, UHI = 6'h08, ULO = 6'h0C;
    localparam logic [5:0] ADDR_ADD = 6'h10, TSEC = 6'h14, TSUB = 6'h18;

    // vector table: start time, increment, mode, addend, ticks, expected time
    localparam int NV = 7;
    localparam logic [31:0] V_SEC0 [NV] = '{32'd5, 32'd7, 32'd0, 32'd1, 32'd2, 32'd3, 32'hFFFF_FFFF};
    localparam logic [30:0] V_SUB0 [NV] = '{31'd0, 31'h7FFF_FFF0, 31'd0, 31'd0, 31'd5, 31'd0, 31'h7FFF_FF00};
    localparam logic [7:0]  V_INC  [NV] = '{8'd10, 8'h20, 8'd4, 8'd3, 8'd100, 8'd50, 8'd255};
    localparam logic        V_FINE [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam logic [31:0] V_ADD  [NV] = '{32'd0, 32'd0, 32'h8000_0000, 32'hFFFF_FFFF, 32'h4000_0000, 32'd0, 32'd0};
    localparam int          V_TCK  [NV] = '{3, 1, 4, 4, 8, 5, 2};
    localparam logic [31:0] V_ESEC [NV] = '{32'd5, 32'd8, 32'd0, 32'd1, 32'd2, 32'd3, 32'd0};
    localparam logic [30:0] V_ESUB [NV] = '{31'd30, 31'h10, 31'd8, 31'd9, 31'd205, 31'd0, 31'hFE};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] hold_sec;
        logic [30:0] hold_sub;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(CTRL, d);  chk("R1 ctrl reset", d, 0);
        rd(INCR, d);  chk("R1 incr reset", d, 0);
        rd(ADDR_ADD, d); chk("R1 addend reset", d, 0);
        chk("R1 time reset", {sys_sec, 1'b0, sys_subsec}, 0);
        chk("R1 flags reset", {stamp_en, trig_irq}, 0);

        // R2 disabled: ticks ignored; R10 command without enable is dropped
        wr(INCR, 32'd9);
        tk(3);
        chk("R2 frozen while disabled", {sys_sec, 1'b0, sys_subsec}, 0);
        wr(CTRL, 32'h4);
        rd(CTRL, d); chk("R10 load without enable", d, 0);
        chk("R2 stamp_en low", stamp_en, 0);

        // R1 reserved bits, R11 increment width
        wr(CTRL, 32'hFFFF_FFC1);
        rd(CTRL, d); chk("R1 reserved read zero", d, 32'h1);
        wr(INCR, 32'hFFFF_FF0A);
        rd(INCR, d); chk("R11 incr upper zero", d, 32'h0A);

        // vector walk: R6 coarse, R7 fine, R3 load, R8 addend copy
        for (int v = 0; v < NV; v++) begin
            wr(INCR, {24'd0, V_INC[v]});
            wr(ADDR_ADD, V_ADD[v]);
            wr(CTRL, 32'h21 | {30'd0, V_FINE[v], 1'b0});
            tk(1);
            wr(UHI, V_SEC0[v]);
            wr(ULO, {1'b0, V_SUB0[v]});
            wr(CTRL, 32'h05 | {30'd0, V_FINE[v], 1'b0});
            tk(1);
            rd(CTRL, d);
            chk("R3 R8 commands self-clear", d, 32'h1 | {30'd0, V_FINE[v], 1'b0});
            tk(V_TCK[v]);
            chk(V_FINE[v] ? "R7 fine advance" : "R6 coarse advance",
                {sys_sec, 1'b0, sys_subsec}, {V_ESEC[v], 1'b0, V_ESUB[v]});
        end

        // R4 interlock with load pending
        wr(UHI, 32'd10);
        wr(ULO, 32'h10);
        wr(CTRL, 32'h5);
        wr(CTRL, 32'h9);
        rd(CTRL, d); chk("R4 offset blocked by load", d, 32'h5);
        wr(CTRL, 32'h1);
        rd(CTRL, d); chk("R4 zero write keeps load", d, 32'h5);
        tk(1);
        chk("R3 load value", {sys_sec, 1'b0, sys_subsec}, {32'd10, 32'h10});
        rd(CTRL, d); chk("R3 load cleared", d, 32'h1);

        // R4 both set in one write: only load
        wr(CTRL, 32'hD);
        rd(CTRL, d); chk("R4 load wins", d, 32'h5);
        tk(1);

        // R5 subtract with borrow
        wr(UHI, 32'd2);
        wr(ULO, 32'h8000_0020);
        wr(CTRL, 32'h9);
        wr(CTRL, 32'h5);
        rd(CTRL, d); chk("R4 load blocked by offset", d, 32'h9);
        tk(1);
        chk("R5 subtract borrow", {sys_sec, 1'b0, sys_subsec}, {32'd7, 32'h7FFF_FFF0});
        rd(CTRL, d); chk("R5 offset cleared", d, 32'h1);

        // R5 add with carry
        wr(UHI, 32'd1);
        wr(ULO, 32'h30);
        wr(CTRL, 32'h9);
        tk(1);
        chk("R5 add carry", {sys_sec, 1'b0, sys_subsec}, {32'd9, 32'h20});

        // R8 addend bit set and cleared
        wr(ADDR_ADD, 32'd5);
        wr(CTRL, 32'h21);
        rd(CTRL, d); chk("R8 addend pending", d, 32'h21);
        tk(1);
        rd(CTRL, d); chk("R8 addend cleared", d, 32'h1);

        // R10 cancel
        wr(INCR, 32'd0);
        hold_sec = sys_sec; hold_sub = sys_subsec;
        wr(UHI, 32'd100);
        wr(ULO, 32'd0);
        wr(CTRL, 32'h5);
        wr(CTRL, 32'h0);
        rd(CTRL, d); chk("R10 cancel clears", d, 32'h0);
        wr(CTRL, 32'h1);
        tk(1);
        chk("R10 no late load", {sys_sec, 1'b0, sys_subsec}, {hold_sec, 1'b0, hold_sub});

        // addend copy and load on the same tick (R8 with R3)
        wr(ADDR_ADD, 32'h8000_0000);
        wr(INCR, 32'd6);
        wr(UHI, 32'd3);
        wr(ULO, 32'd0);
        wr(CTRL, 32'h27);
        rd(CTRL, d); chk("R8 both pending", d, 32'h27);
        tk(1);
        rd(CTRL, d); chk("R8 both cleared", d, 32'h3);
        chk("R3 load same tick", {sys_sec, 1'b0, sys_subsec}, {32'd3, 32'd0});
        tk(2);
        chk("R8 new addend used", {sys_sec, 1'b0, sys_subsec}, {32'd3, 32'd6});

        // R9 target interrupt
        wr(INCR, 32'd10);
        wr(UHI, 32'd0);
        wr(ULO, 32'd0);
        wr(CTRL, 32'h5);
        tk(1);
        wr(TSEC, 32'd0);
        wr(TSUB, 32'd20);
        wr(CTRL, 32'h11);
        tk(2);
        @(negedge clk);
        chk("R9 equal does not fire", trig_irq, 0);
        rd(CTRL, d); chk("R9 still armed", d, 32'h11);
        tk(1);
        @(negedge clk);
        chk("R9 irq pulse", trig_irq, 1);
        rd(CTRL, d); chk("R9 arm cleared", d, 32'h1);
        @(negedge clk);
        chk("R9 single pulse", trig_irq, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule